// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls one port of sixteen general-purpose pins. Each pin has its own configuration: a two-bit operating mode, a drive style (push-pull or open-drain), a two-bit pull selection, a two-bit speed code and one bit of output data. From these settings the block produces the control signals for each pad: drive enable, driven value, pull-up enable, pull-down enable and input-buffer enable. In alternate-function mode the driven value comes from a peripheral rather than from the output data bit.

Software reaches the settings through a small word-addressed register interface. Writes take effect on the clock edge, and read data is a combinational function of the address. A write-only set/clear word changes individual output bits without a read-modify-write sequence. The pin levels pass through a two-stage synchronizer into a read-only input word. Analog circuitry is not part of the block; analog mode only switches off the digital paths of the pin.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While reset is held and until the first register write after it, every pin is in input mode with push-pull type, no pull, speed 0 and output data 0. All read words return 0 except the input word, which follows the pins, and pad_ie is all ones while pad_oe, pad_out, pad_pu and pad_pd are all zeros.
- R2: Word addresses are 0 mode, 1 type, 2 speed, 3 pull, 4 input data, 5 output data and 6 set/clear. Addresses 0, 1, 2, 3 and 5 read back the last value written to their used bits, and unused bits read 0. Addresses 6 and 7 always read 0. A write to address 4 or 7 changes nothing.
- R3: Pin i uses mode bits [2i+1:2i]: 00 input, 01 output, 10 alternate function, 11 analog. In input mode pad_oe is 0. In output mode the value driven is output-data bit i.
- R4: Type bit i set to 0 selects push-pull, where pad_oe is 1 in output and alternate modes and pad_out equals the value driven. Type bit i set to 1 selects open-drain, where pad_oe is 1 only while the value driven is 0. pad_out is 1 only when the pin actively drives high.
- R5: In alternate-function mode the value driven is alt_fn_val[i] and the output-data bit is ignored. The type bit still applies.
- R6: In analog mode pad_oe, pad_out, pad_pu, pad_pd and pad_ie of that pin are all 0, whatever the pull field holds, and its input-data bit is 0.
- R7: Pull bits [2i+1:2i] select none (00), pull-up (01), pull-down (10) or none (11). pad_pu and pad_pd are never both 1.
- R8: A write to address 6 sets output bit i when data bit i is 1 and clears it when data bit 16+i is 1. If both bits are 1, the set wins. Bits whose two write bits are 0 keep their value.
- R9: A change on pad_in appears in the input word at the third rising clock edge after it, through two synchronizer stages and then the input register. Sampling is the same in input, output and alternate modes.
- R10: The speed field is stored and read back only. Writing it changes none of the pad outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| bus_we | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| alt_fn_val | input | 16 | Per-pin output value from an alternate-function peripheral |
| pad_in | input | 16 | Pin levels from the pads |
| pad_oe | output | 16 | Per-pin output-driver enable |
| pad_out | output | 16 | Per-pin driven value |
| pad_pu | output | 16 | Per-pin pull-up enable |
| pad_pd | output | 16 | Per-pin pull-down enable |
| pad_ie | output | 16 | Per-pin input-buffer enable |

## Verification
The bench builds the block with its defaults: sixteen pins and two synchronizer stages. At that size the set/clear word covers the full 32-bit data bus, so set and clear bits for every pin can be driven together in one write. The three-edge input latency can be checked edge by edge. Random register traffic with random pin and peripheral values mixes all four modes and both drive types across pins in the same cycle, and a behavioural model is compared against the outputs on every clock.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    PM_INPUT  = 2'b00,
    PM_OUTPUT = 2'b01,
    PM_ALTFN  = 2'b10,
    PM_ANALOG = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    PULL_NONE = 2'b00,
    PULL_UP   = 2'b01,
    PULL_DOWN = 2'b10,
    PULL_RSVD = 2'b11
  } pin_pull_e;

  localparam logic [ADDR_W-1:0] OFS_MODE   = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_TYPE   = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_SPEED  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_PULL   = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_INDATA = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_OUTDAT = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_SETCLR = 3'd6;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic core_rst_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign core_rst_n = sh_q[STAGES-1];

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [REG_W-1:0]      bus_wdata,
  input  logic [NUM_PINS-1:0]   idr_i,
  output logic [REG_W-1:0]      bus_rdata,
  output logic [2*NUM_PINS-1:0] mode_o,
  output logic [NUM_PINS-1:0]   otype_o,
  output logic [2*NUM_PINS-1:0] pull_o,
  output logic [NUM_PINS-1:0]   odr_o
);

  localparam int FW = 2 * NUM_PINS;

  logic [FW-1:0]       mode_q, speed_q, pull_q;
  logic [NUM_PINS-1:0] otype_q, odr_q, odr_d;
  logic                mode_en, type_en, speed_en, pull_en, odr_en;
  logic [NUM_PINS-1:0] set_bits, clr_bits;

  assign set_bits = bus_wdata[NUM_PINS-1:0];
  assign clr_bits = bus_wdata[FW-1:NUM_PINS];

  always_comb begin
    mode_en  = bus_we && (bus_addr == OFS_MODE);
    type_en  = bus_we && (bus_addr == OFS_TYPE);
    speed_en = bus_we && (bus_addr == OFS_SPEED);
    pull_en  = bus_we && (bus_addr == OFS_PULL);
    odr_en   = bus_we && ((bus_addr == OFS_OUTDAT) || (bus_addr == OFS_SETCLR));
  end

  // output data next state: direct write, or set/clear with set winning
  always_comb begin
    odr_d = odr_q;
    if (bus_addr == OFS_OUTDAT) odr_d = bus_wdata[NUM_PINS-1:0];
    else                        odr_d = (odr_q & ~clr_bits) | set_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      otype_q <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      odr_q   <= '0;
    end else begin
      if (mode_en)  mode_q  <= bus_wdata[FW-1:0];
      if (type_en)  otype_q <= bus_wdata[NUM_PINS-1:0];
      if (speed_en) speed_q <= bus_wdata[FW-1:0];
      if (pull_en)  pull_q  <= bus_wdata[FW-1:0];
      if (odr_en)   odr_q   <= odr_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_MODE:   bus_rdata[FW-1:0]       = mode_q;
      OFS_TYPE:   bus_rdata[NUM_PINS-1:0] = otype_q;
      OFS_SPEED:  bus_rdata[FW-1:0]       = speed_q;
      OFS_PULL:   bus_rdata[FW-1:0]       = pull_q;
      OFS_INDATA: bus_rdata[NUM_PINS-1:0] = idr_i;
      OFS_OUTDAT: bus_rdata[NUM_PINS-1:0] = odr_q;
      default:    bus_rdata               = '0;
    endcase
  end

  assign mode_o  = mode_q;
  assign otype_o = otype_q;
  assign pull_o  = pull_q;
  assign odr_o   = odr_q;

  // set bits land as ones after a set/clear write (set beats clear)
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_SETCLR) |=>
      ((odr_q & $past(set_bits)) == $past(set_bits)));

  // clear-only bits land as zeros
  assert_clear_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_SETCLR) |=>
      ((odr_q & $past(clr_bits & ~set_bits)) == '0));

  // untouched bits keep their value
  assert_setclr_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_SETCLR) |=>
      (((odr_q ^ $past(odr_q)) & ~$past(clr_bits | set_bits)) == '0));

endmodule

// File: rtl/gpio_in_sample.sv
module gpio_in_sample #(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pad_in,
  input  logic [NUM_PINS-1:0] ie_i,
  output logic [NUM_PINS-1:0] idr_o
);

  logic [NUM_PINS-1:0] stg_q [SYNC_STAGES];
  logic [NUM_PINS-1:0] idr_q, idr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= pad_in;
      for (int k = 1; k < SYNC_STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  always_comb begin
    idr_d = stg_q[SYNC_STAGES-1] & ie_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idr_q <= '0;
    else        idr_q <= idr_d;
  end

  assign idr_o = idr_q;

  // a pin with its buffer off captures 0
  assert_idr_off_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idr_q != '1) |=> ((idr_q & ~$past(ie_i)) == '0));

endmodule

// File: rtl/gpio_pad_decode.sv
module gpio_pad_decode
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic [2*NUM_PINS-1:0] mode_i,
  input  logic [NUM_PINS-1:0]   otype_i,
  input  logic [2*NUM_PINS-1:0] pull_i,
  input  logic [NUM_PINS-1:0]   odr_i,
  input  logic [NUM_PINS-1:0]   alt_i,
  output logic [NUM_PINS-1:0]   oe_o,
  output logic [NUM_PINS-1:0]   out_o,
  output logic [NUM_PINS-1:0]   pu_o,
  output logic [NUM_PINS-1:0]   pd_o,
  output logic [NUM_PINS-1:0]   ie_o
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pin_mode_e md;
    pin_pull_e pl;
    logic      drive_en;
    logic      drive_val;
    logic      digital;

    assign md        = pin_mode_e'(mode_i[2*i +: 2]);
    assign pl        = pin_pull_e'(pull_i[2*i +: 2]);
    assign digital   = (md != PM_ANALOG);
    assign drive_en  = (md == PM_OUTPUT) || (md == PM_ALTFN);
    assign drive_val = (md == PM_ALTFN) ? alt_i[i] : odr_i[i];

    assign oe_o[i]  = drive_en && (!otype_i[i] || !drive_val);
    assign out_o[i] = drive_en && !otype_i[i] && drive_val;
    assign pu_o[i]  = digital && (pl == PULL_UP);
    assign pd_o[i]  = digital && (pl == PULL_DOWN);
    assign ie_o[i]  = digital;
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] alt_fn_val,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_pu,
  output logic [NUM_PINS-1:0] pad_pd,
  output logic [NUM_PINS-1:0] pad_ie
);

  localparam int FW = 2 * NUM_PINS;

  logic                core_rst_n;
  logic [FW-1:0]       mode_w, pull_w;
  logic [NUM_PINS-1:0] otype_w, odr_w, idr_w;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_rst_n (core_rst_n)
  );

  gpio_cfg_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .idr_i     (idr_w),
    .bus_rdata (bus_rdata),
    .mode_o    (mode_w),
    .otype_o   (otype_w),
    .pull_o    (pull_w),
    .odr_o     (odr_w)
  );

  gpio_pad_decode #(.NUM_PINS(NUM_PINS)) u_dec (
    .mode_i  (mode_w),
    .otype_i (otype_w),
    .pull_i  (pull_w),
    .odr_i   (odr_w),
    .alt_i   (alt_fn_val),
    .oe_o    (pad_oe),
    .out_o   (pad_out),
    .pu_o    (pad_pu),
    .pd_o    (pad_pd),
    .ie_o    (pad_ie)
  );

  gpio_in_sample #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_in (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .pad_in (pad_in),
    .ie_i   (pad_ie),
    .idr_o  (idr_w)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    assert_input_released_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
      (mode_w[2*i +: 2] == PM_INPUT) |-> !pad_oe[i]);

    assert_output_follows_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
      (mode_w[2*i +: 2] == PM_OUTPUT && !otype_w[i]) |-> (pad_oe[i] && pad_out[i] == odr_w[i]));

    assert_od_never_high_R4: assert property (@(posedge clk) disable iff (!core_rst_n)
      otype_w[i] |-> !pad_out[i]);

    assert_altfn_source_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
      (mode_w[2*i +: 2] == PM_ALTFN && !otype_w[i]) |-> (pad_oe[i] && pad_out[i] == alt_fn_val[i]));

    assert_analog_quiet_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
      (mode_w[2*i +: 2] == PM_ANALOG) |-> !(pad_oe[i] || pad_out[i] || pad_pu[i] || pad_pd[i] || pad_ie[i]));

    assert_pull_exclusive_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
      !(pad_pu[i] && pad_pd[i]));
  end

endmodule

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;

  localparam int NP = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [NP-1:0] alt_fn_val, pad_in, pad_oe, pad_out, pad_pu, pad_pd, pad_ie;

  int n_cmp  = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_port_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_fn_val(alt_fn_val),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
    .pad_pd(pad_pd), .pad_ie(pad_ie)
  );

  // ---------------- behavioural reference model ----------------
  logic [1:0]    m_rs;
  logic [31:0]   m_mode, m_speed, m_pull;
  logic [NP-1:0] m_type, m_odr, m_s1, m_s2, m_idr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs <= 2'b00;
      m_mode <= 0; m_speed <= 0; m_pull <= 0;
      m_type <= 0; m_odr <= 0; m_s1 <= 0; m_s2 <= 0; m_idr <= 0;
    end else begin
      m_rs <= {m_rs[0], 1'b1};
      if (!m_rs[1]) begin
        m_mode <= 0; m_speed <= 0; m_pull <= 0;
        m_type <= 0; m_odr <= 0; m_s1 <= 0; m_s2 <= 0; m_idr <= 0;
      end else begin
        if (bus_we) begin
          case (bus_addr)
            3'd0: m_mode  <= bus_wdata;
            3'd1: m_type  <= bus_wdata[15:0];
            3'd2: m_speed <= bus_wdata;
            3'd3: m_pull  <= bus_wdata;
            3'd5: m_odr   <= bus_wdata[15:0];
            3'd6: begin
              for (int p = 0; p < NP; p++) begin
                if (bus_wdata[p])         m_odr[p] <= 1'b1;
                else if (bus_wdata[16+p]) m_odr[p] <= 1'b0;
              end
            end
            default: ;
          endcase
        end
        m_s1 <= pad_in;
        m_s2 <= m_s1;
        for (int p = 0; p < NP; p++)
          m_idr[p] <= (m_mode[2*p +: 2] == 2'b11) ? 1'b0 : m_s2[p];
      end
    end
  end

  task automatic fail_line(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_fail++;
    $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) fail_line(tag, what, act, exp);
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      logic [NP-1:0] e_oe, e_out, e_pu, e_pd, e_ie;
      logic [31:0]   e_rd;
      string         rtag;
      for (int p = 0; p < NP; p++) begin
        logic [1:0] md;
        logic v, drv;
        md  = m_mode[2*p +: 2];
        v   = (md == 2'b10) ? alt_fn_val[p] : m_odr[p];
        drv = (md == 2'b01) || (md == 2'b10);
        e_oe[p]  = drv && (!m_type[p] || !v);
        e_out[p] = drv && !m_type[p] && v;
        e_pu[p]  = (md != 2'b11) && (m_pull[2*p +: 2] == 2'b01);
        e_pd[p]  = (md != 2'b11) && (m_pull[2*p +: 2] == 2'b10);
        e_ie[p]  = (md != 2'b11);
      end
      case (bus_addr)
        3'd0: begin e_rd = m_mode;           rtag = "R2"; end
        3'd1: begin e_rd = {16'h0, m_type};  rtag = "R2"; end
        3'd2: begin e_rd = m_speed;          rtag = "R10"; end
        3'd3: begin e_rd = m_pull;           rtag = "R2"; end
        3'd4: begin e_rd = {16'h0, m_idr};   rtag = "R9"; end
        3'd5: begin e_rd = {16'h0, m_odr};   rtag = "R8"; end
        default: begin e_rd = 32'h0;         rtag = "R2"; end
      endcase
      chk("R3 R4 R5 R6", "pad_oe",  {16'h0, pad_oe},  {16'h0, e_oe});
      chk("R3 R4 R5 R6", "pad_out", {16'h0, pad_out}, {16'h0, e_out});
      chk("R7 R6", "pad_pu", {16'h0, pad_pu}, {16'h0, e_pu});
      chk("R7 R6", "pad_pd", {16'h0, pad_pd}, {16'h0, e_pd});
      chk("R6", "pad_ie", {16'h0, pad_ie}, {16'h0, e_ie});
      chk(rtag, "bus_rdata", bus_rdata, e_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step();
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    step();
    bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    chk(tag, "directed read", bus_rdata, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_cmp++;
    fail_line("watchdog", "timeout", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    rst_n = 1'b1; bus_we = 1'b0; bus_addr = 3'd0; bus_wdata = '0;
    alt_fn_val = '0; pad_in = '0;
    #1 rst_n = 1'b0;
    #1 cmp_en = 1'b1;
    repeat (5) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    rd_chk("R1", 3'd0, 32'h0);
    rd_chk("R1", 3'd1, 32'h0);
    rd_chk("R1", 3'd2, 32'h0);
    rd_chk("R1", 3'd3, 32'h0);
    rd_chk("R1", 3'd5, 32'h0);
    chk("R1", "pad_ie", {16'h0, pad_ie}, 32'h0000_FFFF);
    chk("R1", "pad_oe", {16'h0, pad_oe}, 32'h0);

    // R10 speed stored only; R2 read-only / write-only words
    wr(3'd2, 32'hA5A5_1234);
    rd_chk("R10", 3'd2, 32'hA5A5_1234);
    chk("R10", "pad_oe after speed", {16'h0, pad_oe}, 32'h0);
    chk("R10", "pad_ie after speed", {16'h0, pad_ie}, 32'h0000_FFFF);
    wr(3'd4, 32'hFFFF_FFFF);
    rd_chk("R2", 3'd4, 32'h0);
    wr(3'd7, 32'hFFFF_FFFF);
    rd_chk("R2", 3'd7, 32'h0);
    rd_chk("R2", 3'd0, 32'h0);
    rd_chk("R2", 3'd5, 32'h0);
    rd_chk("R2", 3'd6, 32'h0);

    // R3 / R4 output mode, push-pull then open-drain
    wr(3'd0, 32'h5555_5555);
    wr(3'd5, 32'h0000_00FF);
    step();
    chk("R3", "pp oe", {16'h0, pad_oe}, 32'h0000_FFFF);
    chk("R3", "pp out", {16'h0, pad_out}, 32'h0000_00FF);
    wr(3'd1, 32'h0000_0F0F);
    step();
    chk("R4", "od oe", {16'h0, pad_oe}, 32'h0000_FFF0);
    chk("R4", "od out", {16'h0, pad_out}, 32'h0000_00F0);

    // R8 set/clear
    wr(3'd5, 32'h0000_00F0);
    wr(3'd6, 32'h0030_0003);
    rd_chk("R8", 3'd5, 32'h0000_00C3);
    wr(3'd6, 32'h0004_0004);
    rd_chk("R8", 3'd5, 32'h0000_00C7);
    wr(3'd6, 32'h0080_0000);
    rd_chk("R8", 3'd5, 32'h0000_0047);

    // R5 alternate function overrides output data
    wr(3'd1, 32'h0);
    wr(3'd0, 32'hAAAA_AAAA);
    alt_fn_val = 16'h1234;
    step();
    chk("R5", "alt out", {16'h0, pad_out}, 32'h0000_1234);
    chk("R5", "alt oe", {16'h0, pad_oe}, 32'h0000_FFFF);

    // R6 analog disables all paths, pulls forced off
    wr(3'd3, 32'h5555_5555);
    wr(3'd0, 32'hFFFF_FFFF);
    pad_in = 16'hFFFF;
    repeat (5) step();
    chk("R6", "analog pu", {16'h0, pad_pu}, 32'h0);
    chk("R6", "analog ie", {16'h0, pad_ie}, 32'h0);
    chk("R6", "analog oe", {16'h0, pad_oe}, 32'h0);
    rd_chk("R6", 3'd4, 32'h0);

    // R7 pull decode with input mode
    wr(3'd0, 32'h0);
    wr(3'd3, 32'h0000_00E4);
    step();
    chk("R7", "pull up", {16'h0, pad_pu}, 32'h0000_0002);
    chk("R7", "pull down", {16'h0, pad_pd}, 32'h0000_0004);

    // R9 input latency of three edges
    pad_in = 16'h0;
    bus_addr = 3'd4;
    repeat (5) step();
    pad_in = 16'h8001;
    @(negedge clk); chk("R9", "idr after edge 1", bus_rdata, 32'h0);
    @(negedge clk); chk("R9", "idr after edge 2", bus_rdata, 32'h0);
    @(negedge clk); chk("R9", "idr after edge 3", bus_rdata, 32'h0000_8001);

    // random traffic, checked every clock by the model
    for (int c = 0; c < 6000; c++) begin
      step();
      bus_we     = (($urandom % 4) == 0);
      bus_addr   = 3'($urandom % 8);
      bus_wdata  = $urandom;
      alt_fn_val = 16'($urandom);
      pad_in     = 16'($urandom);
    end
    step();
    bus_we = 1'b0;
    repeat (4) step();
    finish_run();
  end

endmodule